// File: doc/BRIEF.md
# Programmable interrupt steering matrix

This block connects sixteen level-sensitive input lines to a sixteen-bit interrupt request vector. Software picks the request line for each input and turns each input on or off. Each channel has a three-bit route code and one enable bit. The route codes do not map to request numbers in a linear way. Eight request numbers can be reached. When several enabled inputs share one request line, the output for that line is the OR of their input levels.

The route codes are packed back to back into a 48-bit space. That space is made of three 16-bit selector registers. Channels 5 and 10 therefore have codes that cross from one register into the next.

A small register port writes and reads all four registers: the three selector registers and one enable register. Inputs pass through a two-flop synchronizer. The request vector is registered, so the latency from input to request is fixed.

Top module: `irq_steer_matrix`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every selector and enable register to 0 and drives `irq_out` to 0. Reads then return 0.
- R2: With `reg_we` high at a rising edge, `reg_wdata` is stored in the register at `reg_addr`. Addresses 0, 1 and 2 are selector registers 0, 1 and 2, and address 3 is the enable register. `reg_rdata` shows the register at `reg_addr` without delay and reflects a write from the next edge on.
- R3: Channel n takes its route code from bits 3n+2..3n of {sel2, sel1, sel0}, with bit 0 as the least significant. Channel 5 takes its code bit 0 from sel0 bit 15 and its code bits 2:1 from sel1 bits 1:0. Channel 10 takes its code bits 1:0 from sel1 bits 15:14 and its code bit 2 from sel2 bit 0.
- R4: The route codes 0 to 7 select request numbers 10, 11, 12, 15, 2, 7, 5 and 3, in that order. A request number is the bit index in `irq_out`.
- R5: A channel whose bit in the enable register (bit n for channel n) is 0 has no effect on `irq_out`, whatever its input level or route code.
- R6: When several enabled channels share a request number, that bit of `irq_out` is the OR of their input levels.
- R7: Bits 0, 1, 4, 6, 8, 9, 13 and 14 of `irq_out` are always 0.
- R8: A change on `line_in` reaches `irq_out` on the third rising edge after it is applied, and not before. A register write reaches `irq_out` one edge after it is stored.
- R9: With `reg_we` low, no register changes, whatever the values on `reg_addr` and `reg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 16 | Level inputs, active high, one per channel |
| reg_addr | input | 2 | Register address: 0..2 are selectors, 3 is the enable register |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for the register at `reg_addr` |
| irq_out | output | 16 | Registered interrupt request vector |

## Verification
The bench uses the default parameters: sixteen channels, three-bit codes over three selector registers, and a two-stage synchronizer. These values make every route code reachable. They also include the two channels whose codes cross a register boundary, so the bench can write their bits in the cross-register layout and check the result. With a two-stage synchronizer the bench can measure the input-to-request latency exactly, edge by edge.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned IRQ_W  = 16;
  localparam int unsigned IDX_W  = $clog2(IRQ_W);
  localparam int unsigned ADDR_W = 2;

  // Route code to request number (non-linear table).
  function automatic logic [IDX_W-1:0] code_to_irq(input logic [SEL_W-1:0] code);
    logic [IDX_W-1:0] r;
    case (code)
      3'd0:    r = IDX_W'(10);
      3'd1:    r = IDX_W'(11);
      3'd2:    r = IDX_W'(12);
      3'd3:    r = IDX_W'(15);
      3'd4:    r = IDX_W'(2);
      3'd5:    r = IDX_W'(7);
      3'd6:    r = IDX_W'(5);
      default: r = IDX_W'(3);
    endcase
    return r;
  endfunction

  function automatic logic [IRQ_W-1:0] reachable_mask();
    logic [IRQ_W-1:0] m;
    m = '0;
    for (int c = 0; c < (1 << SEL_W); c++) m[code_to_irq(SEL_W'(c))] = 1'b1;
    return m;
  endfunction

  localparam logic [IRQ_W-1:0] IRQ_REACHABLE = reachable_mask();
endpackage

// File: rtl/irq_steer_sync.sv
module irq_steer_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  input  logic                      reg_we,
  output logic [REG_W-1:0]          reg_rdata,
  output logic [NUM_CH*SEL_W-1:0]   sel_flat,
  output logic [NUM_CH-1:0]         gate
);
  localparam int unsigned NSEL      = (NUM_CH*SEL_W + REG_W - 1) / REG_W;
  localparam int unsigned GATE_ADDR = NSEL;

  logic [REG_W-1:0]  sel_q [NSEL];
  logic [NSEL*REG_W-1:0] sel_space;
  logic [NUM_CH-1:0] gate_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)                                   sel_q[i] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(i)) sel_q[i] <= reg_wdata;
    end
    assign sel_space[i*REG_W +: REG_W] = sel_q[i];

    // R9: registers hold when not written
    assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !reg_we |=> $stable(sel_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst)                                          gate_q <= '0;
    else if (reg_we && reg_addr == ADDR_W'(GATE_ADDR)) gate_q <= reg_wdata[NUM_CH-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSEL; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = sel_q[i];
    if (reg_addr == ADDR_W'(GATE_ADDR)) reg_rdata = REG_W'(gate_q);
  end

  assign sel_flat = sel_space[NUM_CH*SEL_W-1:0];
  assign gate     = gate_q;

  // R1: reset clears the enable register
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (gate_q == '0 && sel_q[0] == '0));

  // R2: enable write lands on the next edge
  assert_gate_write_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_W'(GATE_ADDR)) |=> gate_q == $past(reg_wdata[NUM_CH-1:0]));

  // R9: enable register holds when not written
  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> $stable(gate_q));
endmodule

// File: rtl/irq_steer_route.sv
module irq_steer_route
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       lines,
  input  logic [NUM_CH-1:0]       gate,
  input  logic [NUM_CH*SEL_W-1:0] sel_flat,
  output logic [IRQ_W-1:0]        irq_q
);
  logic [IRQ_W-1:0] hit [NUM_CH];
  logic [IRQ_W-1:0] irq_d;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [SEL_W-1:0] code;
    assign code   = sel_flat[n*SEL_W +: SEL_W];
    assign hit[n] = (lines[n] && gate[n]) ? (IRQ_W'(1) << code_to_irq(code)) : '0;
  end

  always_comb begin
    irq_d = '0;
    for (int n = 0; n < NUM_CH; n++) irq_d = irq_d | hit[n];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end

  // R7: unreachable request bits never assert
  assert_unused_low_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_q & ~IRQ_REACHABLE) == '0);

  // R5: with every channel disabled, no request follows
  assert_all_gated_R5: assert property (@(posedge clk) disable iff (rst)
    gate == '0 |=> irq_q == '0);

  // R1: reset leaves no request
  assert_reset_irq_R1: assert property (@(posedge clk)
    rst |=> irq_q == '0);
endmodule

// File: rtl/irq_steer_matrix.sv
module irq_steer_matrix
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_CH      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   line_in,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic                reg_we,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [IRQ_W-1:0]    irq_out
);
  logic [NUM_CH-1:0]       lines_s;
  logic [NUM_CH*SEL_W-1:0] sel_flat;
  logic [NUM_CH-1:0]       gate;

  irq_steer_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(lines_s));

  irq_steer_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .sel_flat(sel_flat), .gate(gate));

  irq_steer_route #(.NUM_CH(NUM_CH)) u_route (
    .clk(clk), .rst(rst), .lines(lines_s), .gate(gate),
    .sel_flat(sel_flat), .irq_q(irq_out));
endmodule

// File: tb/tb_irq_steer_matrix.sv
module tb_irq_steer_matrix;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] line_in;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic [15:0] reg_rdata;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_steer_matrix dut (
    .clk(clk), .rst(rst), .line_in(line_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_out(irq_out));

  function automatic logic [15:0] model(input logic [47:0] s, input logic [15:0] g,
                                        input logic [15:0] l);
    logic [15:0] r;
    r = '0;
    for (int ch = 0; ch < 16; ch++) begin
      if (g[ch] && l[ch]) begin
        case (s[3*ch +: 3])
          3'd0: r[10] = 1'b1;
          3'd1: r[11] = 1'b1;
          3'd2: r[12] = 1'b1;
          3'd3: r[15] = 1'b1;
          3'd4: r[2]  = 1'b1;
          3'd5: r[7]  = 1'b1;
          3'd6: r[5]  = 1'b1;
          default: r[3] = 1'b1;
        endcase
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic program_all(input logic [47:0] s, input logic [15:0] g);
    wr(2'd0, s[15:0]);
    wr(2'd1, s[31:16]);
    wr(2'd2, s[47:32]);
    wr(2'd3, g);
  endtask

  task automatic settle(input logic [15:0] l);
    line_in = l;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      chk("R1 readback", reg_rdata, 16'h0000);
    end
    chk("R1 irq_out", irq_out, 16'h0000);
  endtask

  task automatic t_regs();
    logic [15:0] pat [4];
    pat[0] = 16'hA5C3; pat[1] = 16'h5A3C; pat[2] = 16'hF00F; pat[3] = 16'h0FF0;
    for (int a = 0; a < 4; a++) wr(2'(a), pat[a]);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      chk("R2 readback", reg_rdata, pat[a]);
    end
    // R9: strobe low, different data at every address
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      reg_addr = 2'(a); reg_wdata = ~pat[a]; reg_we = 1'b0;
    end
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      chk("R9 no write", reg_rdata, pat[a]);
    end
  endtask

  task automatic t_codes();
    for (int c = 0; c < 8; c++) begin
      logic [47:0] s;
      s = '0; s[2:0] = 3'(c);
      program_all(s, 16'h0001);
      settle(16'h0001);
      chk("R4 code map", irq_out, model(s, 16'h0001, 16'h0001));
    end
  endtask

  task automatic t_straddle();
    logic [47:0] s;
    // channel 5 code 5: sel0[15]=1, sel1[1:0]=2'b10
    s = '0; s[15] = 1'b1; s[17] = 1'b1;
    program_all(s, 16'h0020);
    settle(16'h0020);
    chk("R3 ch5 straddle", irq_out, 16'h0080);
    // channel 5 code 6: sel0[15]=0, sel1[1:0]=2'b11
    s = '0; s[16] = 1'b1; s[17] = 1'b1;
    program_all(s, 16'h0020);
    settle(16'h0020);
    chk("R3 ch5 straddle", irq_out, 16'h0020);
    // channel 10 code 3: sel1[15:14]=2'b11, sel2[0]=0
    s = '0; s[30] = 1'b1; s[31] = 1'b1;
    program_all(s, 16'h0400);
    settle(16'h0400);
    chk("R3 ch10 straddle", irq_out, 16'h8000);
    // channel 10 code 4: sel2[0]=1 only
    s = '0; s[32] = 1'b1;
    program_all(s, 16'h0400);
    settle(16'h0400);
    chk("R3 ch10 straddle", irq_out, 16'h0004);
  endtask

  task automatic t_gate();
    logic [47:0] s;
    s = 48'hFAC6_88D1_2345;
    program_all(s, 16'h0000);
    settle(16'hFFFF);
    chk("R5 all gated", irq_out, 16'h0000);
    wr(2'd3, 16'h00F0);
    @(negedge clk);
    chk("R5 partial gate", irq_out, model(s, 16'h00F0, 16'hFFFF));
  endtask

  task automatic t_or();
    logic [47:0] s;
    s = '0; // channels 1 and 2 both code 0 -> IRQ10
    program_all(s, 16'h0006);
    settle(16'h0002); chk("R6 ch1 only", irq_out, 16'h0400);
    settle(16'h0004); chk("R6 ch2 only", irq_out, 16'h0400);
    settle(16'h0006); chk("R6 both", irq_out, 16'h0400);
    settle(16'h0000); chk("R6 none", irq_out, 16'h0000);
  endtask

  task automatic t_unused();
    logic [47:0] s;
    s = 48'h9C3B_17E5_D2A6;
    program_all(s, 16'hFFFF);
    settle(16'hFFFF);
    chk("R7 unused bits", irq_out & 16'h6353, 16'h0000);
    chk("R7 full map", irq_out, model(s, 16'hFFFF, 16'hFFFF));
  endtask

  task automatic t_latency();
    logic [47:0] s;
    s = '0;
    program_all(s, 16'h0001);
    settle(16'h0000);
    line_in = 16'h0001;
    repeat (2) @(negedge clk);
    chk("R8 not yet", irq_out, 16'h0000);
    @(negedge clk);
    chk("R8 third edge", irq_out, 16'h0400);
    // config write visible one edge after storage
    wr(2'd0, 16'h0003);
    chk("R8 before config edge", irq_out, 16'h0400);
    @(negedge clk);
    chk("R8 config edge", irq_out, 16'h8000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; line_in = '0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_codes();
    t_straddle();
    t_gate();
    t_or();
    t_unused();
    t_latency();
    program_all(48'hFFFF_FFFF_FFFF, 16'hFFFF);
    line_in = 16'hFFFF;
    do_reset();
    t_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule